// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block keeps one processor's small direct-mapped cache coherent with the other caches on a shared bus. Each line holds one data word, a tag and one of three states: Invalid, Shared (clean, read only) or Modified (the single up-to-date copy; memory is stale). Local reads, writes and evictions are served in the same cycle when the line state allows it. Otherwise the controller asks for the bus and waits for a grant, then for the response, with the processor held busy. Only then does it update the line.

At the same time the controller watches every transaction that other nodes put on the bus. A snooped bus read or read-exclusive is compared in the same cycle against the indexed line. When the line is Modified, the controller drives the line's word onto the bus in place of memory and tells memory to drop its own access. The line then moves to Shared or Invalid, depending on the command. A snoop always wins over a new local request presented in the same cycle. Encodings: processor operation 0 = read, 1 = write, 2 = evict. Bus and snoop commands 1 = read, 2 = read-exclusive, 3 = write-back, 0 = idle. The line index is the low `log2(LINES)` address bits and the tag is the rest.

Top module: `coh_node_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop reports a shared hit or a flush, and the first processor access to any address goes to the bus.
- R2: A processor read whose line is Invalid or holds another tag issues one bus read (cmd 1) at that address. It returns the bus data and leaves the line Shared, so a later snooped read reports a shared hit without a flush.
- R3: A processor write whose line is Invalid issues one bus read-exclusive (cmd 2) and leaves the line Modified with the written word.
- R4: A processor write to a Shared line issues a bus read-exclusive as an upgrade. The data returned on the bus is discarded, and the line ends Modified, holding the processor's word.
- R5: Reads that hit Shared or Modified lines, and writes that hit Modified lines, finish in the cycle they are presented and cause no bus transaction.
- R6: A snooped bus read that hits a Modified line asserts flush and memory-abort with the line's word in the same cycle, and the line becomes Shared. A snooped read of a Shared line only reports a shared hit.
- R7: A snooped read-exclusive that hits a Modified line flushes its word and invalidates the line. On a Shared line it reports a shared hit, gives no flush, and invalidates the line.
- R8: Evicting a Modified line issues one bus write-back (cmd 3) carrying the line's address and word, and leaves it Invalid. Evicting a Shared line, or an address not present, finishes at once with no bus traffic, and the line is left Invalid.
- R9: A read or write miss whose line holds a Modified block of another tag first writes that victim back at the victim's own address. It then issues the fill.
- R10: While a transaction waits for grant or response, busy stays high and the bus request is held stable. Snoops arriving in that time are still answered in their own cycle. A processor request presented while a snoop is valid is not accepted until the snoop has gone.
- R11: A snoop whose tag differs from the indexed line's tag reports nothing and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_busy | output | 1 | A bus transaction is outstanding |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done on a read |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Command driven while requesting |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_resp | input | 1 | Data or acknowledge for the granted transaction |
| bus_rdata | input | DATA_W | Fill data |
| snoop_valid | input | 1 | Another node's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_shared_hit | output | 1 | Snoop matched a Shared line |
| snoop_flush | output | 1 | Snoop matched a Modified line; word supplied |
| snoop_data | output | DATA_W | Flushed word |
| mem_abort | output | 1 | Memory must drop its access and capture the flush |

## Verification
The hardest situation to reach is a snoop landing on the very line whose upgrade is still stalled for the bus grant. The line must answer as Shared in that cycle, and the pending read-exclusive must still finish as Modified with the processor's word. The bench withholds the grant from its bus model, confirms busy and a stable request, injects the snoop, and then releases the grant. A second forked scenario keeps a snoop valid across the cycles in which a hit is presented, and measures that completion waits for the snoop to go.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2} cpu_op_t;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          a_idx,
  output line_st_t                  a_st,
  output logic [TAG_W-1:0]          a_tag,
  output logic [DATA_W-1:0]         a_data,
  input  logic [IDX_W-1:0]          b_idx,
  output line_st_t                  b_st,
  output logic [TAG_W-1:0]          b_tag,
  output logic [DATA_W-1:0]         b_data,
  input  logic                      su_en,
  input  logic [IDX_W-1:0]          su_idx,
  input  line_st_t                  su_st,
  input  logic                      cw_en,
  input  logic [IDX_W-1:0]          cw_idx,
  input  line_st_t                  cw_st,
  input  logic [TAG_W-1:0]          cw_tag,
  input  logic [DATA_W-1:0]         cw_data,
  output logic [LINES-1:0][1:0]     st_all
);
  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Controller writes win over snoop state updates to the same line.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        st_q[i]   <= LS_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (cw_en && cw_idx == IDX_W'(i)) begin
        st_q[i]   <= cw_st;
        tag_q[i]  <= cw_tag;
        data_q[i] <= cw_data;
      end else if (su_en && su_idx == IDX_W'(i)) begin
        st_q[i]   <= su_st;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_probe
    assign st_all[g] = st_q[g];
  end
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  bus_cmd_t          cmd,
  input  logic [TAG_W-1:0]  tag,
  input  line_st_t          ent_st,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_data,
  output logic              shared_hit,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data,
  output logic              upd_en,
  output line_st_t          upd_st
);
  logic relevant;
  logic match;

  assign relevant   = valid && (cmd == BC_RD || cmd == BC_RDX);
  assign match      = relevant && ent_st != LS_I && ent_tag == tag;
  assign shared_hit = match && ent_st == LS_S;
  assign flush      = match && ent_st == LS_M;
  assign flush_data = flush ? ent_data : '0;
  assign upd_en     = match && (cmd == BC_RDX || ent_st == LS_M);
  assign upd_st     = (cmd == BC_RDX) ? LS_I : LS_S;
endmodule

// File: rtl/coh_bus_port.sv
module coh_bus_port
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bus_cmd_t          start_cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              bus_gnt,
  input  logic              bus_resp,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done
);
  typedef enum logic [1:0] {BP_IDLE, BP_REQ, BP_RESP} bp_st_t;
  bp_st_t            st;
  bus_cmd_t          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign done = (st == BP_RESP) && bus_resp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= BP_IDLE;
      cmd_q  <= BC_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      st     <= BP_REQ;
      cmd_q  <= start_cmd;
      addr_q <= start_addr;
      data_q <= start_data;
    end else begin
      case (st)
        BP_REQ:  if (bus_gnt) st <= BP_RESP;
        BP_RESP: if (bus_resp) st <= BP_IDLE;
        default: st <= BP_IDLE;
      endcase
    end
  end

  assign bus_req   = (st == BP_REQ);
  assign bus_cmd   = (st == BP_REQ) ? cmd_q : BC_NONE;
  assign bus_addr  = (st == BP_REQ) ? addr_q : '0;
  assign bus_wdata = (st == BP_REQ) ? data_q : '0;

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_start_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == BP_IDLE || done));
endmodule

// File: rtl/coh_node_ctrl.sv
module coh_node_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_resp,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared_hit,
  output logic              snoop_flush,
  output logic [DATA_W-1:0] snoop_data,
  output logic              mem_abort
);
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction
  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  typedef enum logic [1:0] {PS_IDLE, PS_WB, PS_FILL} ps_t;
  ps_t               ps, nxt;
  cpu_op_t           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  bus_cmd_t          fill_q, fill_d;

  // array ports
  line_st_t          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic [LINES-1:0][1:0] st_all;
  logic              su_en;
  line_st_t          su_st;
  logic              cw_en;
  logic [IDX_W-1:0]  cw_idx;
  line_st_t          cw_st;
  logic [TAG_W-1:0]  cw_tag;
  logic [DATA_W-1:0] cw_data;

  // bus port
  logic              bp_start, bp_done;
  bus_cmd_t          bp_cmd, bus_cmd_e;
  logic [ADDR_W-1:0] bp_addr;
  logic [DATA_W-1:0] bp_data;

  // named internal events
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  snp_idx;
  logic              hit_loc, accept, ctrl_same;
  bus_cmd_t          snp_cmd_e;
  cpu_op_t           op_e;

  assign look_addr = (ps == PS_IDLE) ? cpu_addr : addr_q;
  assign snp_idx   = idx_of(snoop_addr);
  assign snp_cmd_e = bus_cmd_t'(snoop_cmd);
  assign op_e      = cpu_op_t'(cpu_op);
  assign hit_loc   = (b_st != LS_I) && (b_tag == tag_of(look_addr));
  assign accept    = (ps == PS_IDLE) && cpu_req && !snoop_valid;

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(snp_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(idx_of(look_addr)), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .su_en(su_en), .su_idx(snp_idx), .su_st(su_st),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_st(cw_st), .cw_tag(cw_tag), .cw_data(cw_data),
    .st_all(st_all)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .valid(snoop_valid), .cmd(snp_cmd_e), .tag(tag_of(snoop_addr)),
    .ent_st(a_st), .ent_tag(a_tag), .ent_data(a_data),
    .shared_hit(snoop_shared_hit), .flush(snoop_flush), .flush_data(snoop_data),
    .upd_en(su_en), .upd_st(su_st)
  );
  assign mem_abort = snoop_flush;

  coh_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .start(bp_start), .start_cmd(bp_cmd), .start_addr(bp_addr), .start_data(bp_data),
    .bus_gnt(bus_gnt), .bus_resp(bus_resp),
    .bus_req(bus_req), .bus_cmd(bus_cmd_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(bp_done)
  );
  assign bus_cmd = bus_cmd_e;

  always_comb begin
    nxt      = ps;
    cpu_done = 1'b0;
    cw_en    = 1'b0;
    cw_idx   = idx_of(look_addr);
    cw_st    = b_st;
    cw_tag   = b_tag;
    cw_data  = b_data;
    bp_start = 1'b0;
    bp_cmd   = BC_NONE;
    bp_addr  = look_addr;
    bp_data  = b_data;
    fill_d   = fill_q;
    case (ps)
      PS_IDLE: if (accept) begin
        if (op_e == OP_EV) begin
          if (hit_loc && b_st == LS_M) begin
            bp_start = 1'b1;
            bp_cmd   = BC_WB;
            nxt      = PS_WB;
          end else begin
            cpu_done = 1'b1;
            cw_en    = hit_loc;
            cw_st    = LS_I;
          end
        end else if (op_e == OP_RD && hit_loc) begin
          cpu_done = 1'b1;
        end else if (op_e == OP_WR && hit_loc && b_st == LS_M) begin
          cpu_done = 1'b1;
          cw_en    = 1'b1;
          cw_data  = cpu_wdata;
        end else if (op_e == OP_RD || op_e == OP_WR) begin
          fill_d = (op_e == OP_RD) ? BC_RD : BC_RDX;
          if (!hit_loc && b_st == LS_M) begin
            bp_start = 1'b1;
            bp_cmd   = BC_WB;
            bp_addr  = join_addr(b_tag, idx_of(look_addr));
            nxt      = PS_WB;
          end else begin
            bp_start = 1'b1;
            bp_cmd   = fill_d;
            nxt      = PS_FILL;
          end
        end else begin
          cpu_done = 1'b1;
        end
      end
      PS_WB: if (bp_done) begin
        cw_en = 1'b1;
        cw_st = LS_I;
        if (op_q == OP_EV) begin
          cpu_done = 1'b1;
          nxt      = PS_IDLE;
        end else begin
          bp_start = 1'b1;
          bp_cmd   = fill_q;
          nxt      = PS_FILL;
        end
      end
      PS_FILL: if (bp_done) begin
        cw_en    = 1'b1;
        cw_tag   = tag_of(addr_q);
        cw_st    = (fill_q == BC_RDX) ? LS_M : LS_S;
        cw_data  = (fill_q == BC_RDX) ? wdata_q : bus_rdata;
        cpu_done = 1'b1;
        nxt      = PS_IDLE;
      end
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps      <= PS_IDLE;
      op_q    <= OP_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      fill_q  <= BC_NONE;
    end else begin
      ps <= nxt;
      if (accept) begin
        op_q    <= op_e;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
        fill_q  <= fill_d;
      end
    end
  end

  assign cpu_busy  = (ps != PS_IDLE);
  assign cpu_rdata = (ps == PS_FILL) ? bus_rdata : b_data;
  assign ctrl_same = cw_en && (cw_idx == snp_idx);

  assert_snoop_rd_demote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_flush && snp_cmd_e == BC_RD && !ctrl_same)
      |=> st_all[$past(snp_idx)] == LS_S);

  assert_snoop_rdx_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snp_cmd_e == BC_RDX && (snoop_shared_hit || snoop_flush) && !ctrl_same)
      |=> st_all[$past(snp_idx)] == LS_I);

  assert_read_fill_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_FILL && bp_done && fill_q == BC_RD) |=> st_all[$past(idx_of(addr_q))] == LS_S);

  assert_excl_fill_modified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_FILL && bp_done && fill_q == BC_RDX) |=> st_all[$past(idx_of(addr_q))] == LS_M);

  assert_writeback_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_WB && bp_done) |=> st_all[$past(idx_of(addr_q))] == LS_I);

  assert_snoop_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snoop_shared_hit, snoop_flush}));
endmodule

// File: tb/coh_node_ctrl_test.sv
`timescale 1ns/1ps
module coh_node_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0;
  logic [1:0]  cpu_op = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req;
  logic        bus_gnt = 0;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_resp = 0;
  logic [31:0] bus_rdata = 0;
  logic        snoop_valid = 0;
  logic [1:0]  snoop_cmd = 0;
  logic [15:0] snoop_addr = 0;
  logic        snoop_shared_hit, snoop_flush, mem_abort;
  logic [31:0] snoop_data;

  coh_node_ctrl uut (.*);

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [256];
  int n_txn = 0;
  logic [1:0]  last_cmd, prev_cmd;
  logic [15:0] last_addr, prev_addr;
  logic [31:0] last_wdata, prev_wdata;
  logic        pend = 0, hold_gnt = 0;
  logic [1:0]  pend_cmd;
  logic [15:0] pend_addr;
  logic [31:0] pend_wdata;

  // bus and memory model
  always @(negedge clk) begin
    bus_gnt  = 0;
    bus_resp = 0;
    if (rst_n) begin
      if (pend) begin
        bus_resp = 1;
        if (pend_cmd == 2'd3) begin
          mem[pend_addr[7:0]] = pend_wdata;
          bus_rdata = 0;
        end else bus_rdata = mem[pend_addr[7:0]];
        pend = 0;
      end else if (bus_req && !hold_gnt) begin
        bus_gnt = 1;
        pend = 1;
        pend_cmd = bus_cmd; pend_addr = bus_addr; pend_wdata = bus_wdata;
        n_txn++;
        prev_cmd = last_cmd; prev_addr = last_addr; prev_wdata = last_wdata;
        last_cmd = bus_cmd; last_addr = bus_addr; last_wdata = bus_wdata;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic cpu_access(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output int wait_cyc);
    @(negedge clk);
    cpu_req = 1; cpu_op = op; cpu_addr = a; cpu_wdata = d;
    wait_cyc = 0;
    forever begin
      #1;
      if (cpu_done) break;
      @(negedge clk);
      wait_cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic snoop_probe(input string rq, input logic [1:0] c, input logic [15:0] a,
                             input logic eh, input logic ef, input logic [31:0] ed);
    @(negedge clk);
    snoop_valid = 1; snoop_cmd = c; snoop_addr = a;
    #1;
    chk(rq, "snoop shared hit", snoop_shared_hit, eh);
    chk(rq, "snoop flush", snoop_flush, ef);
    chk(rq, "memory abort", mem_abort, ef);
    if (ef) begin
      chk(rq, "flush data", snoop_data, ed);
      mem[a[7:0]] = snoop_data;
    end
    @(negedge clk);
    snoop_valid = 0;
  endtask

  logic [31:0] rd;
  int w, t0;

  task automatic t_reset();
    #1;
    chk("R1", "busy after reset", cpu_busy, 0);
    chk("R1", "bus_req after reset", bus_req, 0);
    chk("R1", "done idle", cpu_done, 0);
    snoop_probe("R1", 2'd1, 16'h0000, 0, 0, 0);
    snoop_probe("R1", 2'd2, 16'h0011, 0, 0, 0);
  endtask

  task automatic t_read_miss();
    t0 = n_txn;
    cpu_access(2'd0, 16'h0010, 0, rd, w);
    chk("R2", "read miss txn count", n_txn - t0, 1);
    chk("R2", "read miss cmd", last_cmd, 1);
    chk("R2", "read miss addr", last_addr, 16'h0010);
    chk("R2", "read miss data", rd, 32'hA000_0010);
    t0 = n_txn;
    cpu_access(2'd0, 16'h0010, 0, rd, w);
    chk("R5", "read hit S no txn", n_txn - t0, 0);
    chk("R5", "read hit S same cycle", w, 0);
    chk("R5", "read hit S data", rd, 32'hA000_0010);
    snoop_probe("R2", 2'd1, 16'h0010, 1, 0, 0);
  endtask

  task automatic t_write_miss_and_upgrade();
    t0 = n_txn;
    cpu_access(2'd1, 16'h0021, 32'h1111_2222, rd, w);
    chk("R3", "write miss txn", n_txn - t0, 1);
    chk("R3", "write miss cmd", last_cmd, 2);
    chk("R3", "write miss addr", last_addr, 16'h0021);
    snoop_probe("R6", 2'd1, 16'h0021, 0, 1, 32'h1111_2222);
    snoop_probe("R6", 2'd1, 16'h0021, 1, 0, 0);
    t0 = n_txn;
    cpu_access(2'd1, 16'h0021, 32'h0000_3333, rd, w);
    chk("R4", "upgrade txn", n_txn - t0, 1);
    chk("R4", "upgrade cmd", last_cmd, 2);
    t0 = n_txn;
    cpu_access(2'd0, 16'h0021, 0, rd, w);
    chk("R4", "upgrade keeps cpu word", rd, 32'h0000_3333);
    chk("R5", "read hit M no txn", n_txn - t0, 0);
  endtask

  task automatic t_snoop_excl();
    snoop_probe("R7", 2'd2, 16'h0021, 0, 1, 32'h0000_3333);
    t0 = n_txn;
    cpu_access(2'd0, 16'h0021, 0, rd, w);
    chk("R7", "invalid after rdx on M", n_txn - t0, 1);
    chk("R7", "refetch flushed word", rd, 32'h0000_3333);
    snoop_probe("R7", 2'd2, 16'h0021, 1, 0, 0);
    t0 = n_txn;
    cpu_access(2'd0, 16'h0021, 0, rd, w);
    chk("R7", "invalid after rdx on S", n_txn - t0, 1);
  endtask

  task automatic t_write_hit_and_evict();
    cpu_access(2'd1, 16'h0042, 32'h0000_5A5A, rd, w);
    t0 = n_txn;
    cpu_access(2'd1, 16'h0042, 32'h0000_0055, rd, w);
    chk("R5", "write hit M no txn", n_txn - t0, 0);
    chk("R5", "write hit M same cycle", w, 0);
    t0 = n_txn;
    cpu_access(2'd2, 16'h0042, 0, rd, w);
    chk("R8", "evict M txn", n_txn - t0, 1);
    chk("R8", "evict M cmd", last_cmd, 3);
    chk("R8", "evict M addr", last_addr, 16'h0042);
    chk("R8", "evict M data", last_wdata, 32'h0000_0055);
    t0 = n_txn;
    cpu_access(2'd0, 16'h0042, 0, rd, w);
    chk("R8", "line invalid after evict", n_txn - t0, 1);
    chk("R8", "memory took write-back", rd, 32'h0000_0055);
    t0 = n_txn;
    cpu_access(2'd2, 16'h0042, 0, rd, w);
    chk("R8", "evict S no txn", n_txn - t0, 0);
    chk("R8", "evict S same cycle", w, 0);
    snoop_probe("R8", 2'd1, 16'h0042, 0, 0, 0);
    t0 = n_txn;
    cpu_access(2'd2, 16'h0043, 0, rd, w);
    chk("R8", "evict absent no txn", n_txn - t0, 0);
  endtask

  task automatic t_victim();
    cpu_access(2'd1, 16'h0013, 32'h0000_0077, rd, w);
    t0 = n_txn;
    cpu_access(2'd0, 16'h001B, 0, rd, w);
    chk("R9", "victim txn count", n_txn - t0, 2);
    chk("R9", "first is write-back", prev_cmd, 3);
    chk("R9", "victim address", prev_addr, 16'h0013);
    chk("R9", "victim data", prev_wdata, 32'h0000_0077);
    chk("R9", "then read", last_cmd, 1);
    chk("R9", "fill address", last_addr, 16'h001B);
    chk("R9", "fill data", rd, 32'hA000_001B);
  endtask

  task automatic t_tag_mismatch();
    snoop_probe("R11", 2'd1, 16'h0013, 0, 0, 0);
    snoop_probe("R11", 2'd2, 16'h0013, 0, 0, 0);
    t0 = n_txn;
    cpu_access(2'd0, 16'h001B, 0, rd, w);
    chk("R11", "line unchanged by mismatch", n_txn - t0, 0);
  endtask

  task automatic t_stall();
    hold_gnt = 1;
    t0 = n_txn;
    fork
      begin
        logic [31:0] r1; int w1;
        cpu_access(2'd1, 16'h001B, 32'h0000_0099, r1, w1);
      end
      begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "busy while stalled", cpu_busy, 1);
        chk("R10", "request held", bus_req, 1);
        chk("R10", "request cmd", bus_cmd, 2);
        snoop_probe("R10", 2'd1, 16'h001B, 1, 0, 0);
        #1;
        chk("R10", "still busy after snoop", cpu_busy, 1);
        hold_gnt = 0;
      end
    join
    chk("R10", "one upgrade txn", n_txn - t0, 1);
    t0 = n_txn;
    cpu_access(2'd0, 16'h001B, 0, rd, w);
    chk("R10", "stalled write landed", rd, 32'h0000_0099);
    chk("R10", "no txn on hit", n_txn - t0, 0);
    fork
      begin
        cpu_access(2'd0, 16'h001B, 0, rd, w);
      end
      begin
        @(negedge clk);
        snoop_valid = 1; snoop_cmd = 2'd1; snoop_addr = 16'h00F5;
        #1;
        chk("R10", "no completion during snoop", cpu_done, 0);
        repeat (2) @(negedge clk);
        snoop_valid = 0;
      end
    join
    chk("R10", "request waits for snoop", w, 2);
    chk("R10", "data after snoop", rd, 32'h0000_0099);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_miss();
    t_write_miss_and_upgrade();
    t_snoop_excl();
    t_write_hit_and_evict();
    t_victim();
    t_tag_mismatch();
    t_stall();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule